// File: doc/BRIEF.md
# Misaligned Word Access Splitter

This block accepts a four-byte access request at any byte address and turns it into one or two beats for a 64-bit data bus. Each beat carries a three-bit size code, its own byte address and an eight-bit byte-lane enable. An access whose four bytes stay inside one aligned 32-bit word goes out as a single beat. An access that straddles a word boundary is cut at that boundary. The first beat covers the bytes from the request address up to the end of its word. The second beat starts at the first byte of the next word and covers what remains.

The request side is a valid/ready handshake. `req_ready` is high only when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From then on `req_ready` stays low until the bus has acknowledged the final beat. The bus side presents one beat at a time on `beat_valid`. A beat is consumed on an edge where `beat_ack` is high. While `beat_ack` is low, the beat is held unchanged. This is the back-pressure rule of the bus side, and a beat may be stalled for any number of cycles.

Top module: `word_split_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request taken, `req_ready` is 1 and `beat_valid` is 0.
- R2: A request with address bits [1:0] = 00 produces exactly one beat. That beat has the request address, size code 100 and `beat_last` = 1. Its lanes are 0–3 when address bit 2 is 0 and 4–7 when it is 1.
- R3: A request with address bits [1:0] = k ≠ 0 first produces a beat at the request address with size code 4−k. Its lanes run from lane number address[2:0] up to the last byte of that word.
- R4: The second beat of a split request has address bits [1:0] = 00 and size code k. Its address equals the request address rounded down to a word and increased by 4. Its lanes start at lane address[2:0] of the new address.
- R5: When the request address bits [2:0] are 101, 110 or 111, the second beat has address bits [2:0] = 000 and its upper address bits are the request's upper bits plus one doubleword. This arithmetic wraps at the top of the address space. The second beat's size is 001, 010 or 011, on lanes 0, 0–1 or 0–2.
- R6: A presented beat keeps its address, size and lanes unchanged, and `beat_valid` stays high, until it is acknowledged.
- R7: `req_ready` goes low on the cycle after a request is taken and stays low while any beat of it is outstanding. It returns high on the cycle after the final beat's acknowledge.
- R8: In every beat the number of enabled lanes equals the size code (100 = 4 bytes, 011 = 3, 010 = 2, 001 = 1). The lanes enabled across the beats of one request always total four.
- R9: `beat_last` is 1 on the final beat of a request and 0 on the first beat of a split request. A split request's first beat always comes before its second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the four-byte access |
| beat_valid | output | 1 | A beat is presented |
| beat_ack | input | 1 | Bus consumes the presented beat |
| beat_addr | output | ADDR_W | Byte address of the presented beat |
| beat_size | output | $clog2(WORD_BYTES)+1 | Size code of the beat, equal to its byte count |
| beat_lanes | output | BUS_BYTES | Byte-lane enables of the beat |
| beat_last | output | 1 | The presented beat is the request's final one |

## Verification
On every cycle, the assertions check several rules. A stalled beat stays stable. A lane count always matches the size code. The first enabled lane sits at the beat's low address bits. A second beat is word-aligned and final. Ready drops after a take and returns after the last acknowledge. Only the bench scenarios can show that each address yields the right split: all eight low-address values, upper-bit increments that carry and wrap at the top of the address space, and the order of beats against an expected queue under varied acknowledge stalls. They also show that the two beats together cover four lanes.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/wsplit_ctrl.sv
module wsplit_ctrl
  import wsplit_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   beat_ack,
  input  logic   split,
  output logic   take,
  output phase_e phase
);
  phase_e phase_d;

  assign take = (phase == PH_IDLE) && req_valid;

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_IDLE:   if (req_valid) phase_d = PH_FIRST;
      PH_FIRST:  if (beat_ack) phase_d = split ? PH_SECOND : PH_IDLE;
      PH_SECOND: if (beat_ack) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/wsplit_plan.sv
module wsplit_plan #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int SZ_W      = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              second,
  output logic              split,
  output logic              last,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SZ_W-1:0]   out_size
);
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] next_word;

  assign off       = base_addr[OFF_W-1:0];
  assign split     = (off != '0);
  assign next_word = {base_addr[ADDR_W-1:OFF_W] + 1'b1, {OFF_W{1'b0}}};

  always_comb begin
    if (second) begin
      out_addr = next_word;
      out_size = SZ_W'(off);
    end else begin
      out_addr = base_addr;
      out_size = SZ_W'(WORD_BYTES) - SZ_W'(off);
    end
  end

  assign last = second || !split;
endmodule

// File: rtl/wsplit_lane_dec.sv
module wsplit_lane_dec #(
  parameter int BUS_BYTES  = 8,
  parameter int WORD_BYTES = 4,
  localparam int LIDX_W    = $clog2(BUS_BYTES),
  localparam int SZ_W      = $clog2(WORD_BYTES) + 1,
  localparam int CW        = LIDX_W + SZ_W + 1
) (
  input  logic [LIDX_W-1:0]    lo,
  input  logic [SZ_W-1:0]      size,
  output logic [BUS_BYTES-1:0] lanes
);
  logic [CW-1:0] lo_x;
  logic [CW-1:0] hi_x;

  assign lo_x = CW'(lo);
  assign hi_x = lo_x + CW'(size);

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign lanes[i] = (CW'(i) >= lo_x) && (CW'(i) < hi_x);
  end
endmodule

// File: rtl/word_split_unit.sv
module word_split_unit
  import wsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          beat_valid,
  input  logic                          beat_ack,
  output logic [ADDR_W-1:0]             beat_addr,
  output logic [$clog2(WORD_BYTES):0]   beat_size,
  output logic [BUS_BYTES-1:0]          beat_lanes,
  output logic                          beat_last
);
  localparam int LIDX_W = $clog2(BUS_BYTES);

  phase_e            phase;
  logic              take;
  logic              split;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (take) addr_q <= req_addr;
  end

  wsplit_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .beat_ack  (beat_ack),
    .split     (split),
    .take      (take),
    .phase     (phase)
  );

  wsplit_plan #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_plan (
    .base_addr (addr_q),
    .second    (phase == PH_SECOND),
    .split     (split),
    .last      (beat_last),
    .out_addr  (beat_addr),
    .out_size  (beat_size)
  );

  wsplit_lane_dec #(
    .BUS_BYTES  (BUS_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) u_lanes (
    .lo    (beat_addr[LIDX_W-1:0]),
    .size  (beat_size),
    .lanes (beat_lanes)
  );

  assign req_ready  = (phase == PH_IDLE);
  assign beat_valid = (phase != PH_IDLE);
endmodule

// File: rtl/wsplit_checker.sv
module wsplit_checker #(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 8,
  parameter int WORD_BYTES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic                        beat_valid,
  input logic                        beat_ack,
  input logic [ADDR_W-1:0]           beat_addr,
  input logic [$clog2(WORD_BYTES):0] beat_size,
  input logic [BUS_BYTES-1:0]        beat_lanes,
  input logic                        beat_last
);
  localparam int LIDX_W = $clog2(BUS_BYTES);
  localparam int OFF_W  = $clog2(WORD_BYTES);

  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && (int'(beat_size) == WORD_BYTES) |-> beat_last);

  p_start_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_lanes[beat_addr[LIDX_W-1:0]]);

  p_second_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ack && !beat_last |=>
      beat_valid && beat_last && (beat_addr[OFF_W-1:0] == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ack |=>
      beat_valid && $stable(beat_addr) && $stable(beat_size) && $stable(beat_lanes));

  p_take_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> beat_valid && !req_ready);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ack && beat_last |=> req_ready && !beat_valid);

  p_lane_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> $countones(beat_lanes) == int'(beat_size));
endmodule

bind word_split_unit wsplit_checker #(
  .ADDR_W     (ADDR_W),
  .BUS_BYTES  (BUS_BYTES),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .beat_valid (beat_valid),
  .beat_ack   (beat_ack),
  .beat_addr  (beat_addr),
  .beat_size  (beat_size),
  .beat_lanes (beat_lanes),
  .beat_last  (beat_last)
);

// File: tb/word_split_unit_tb.sv
module word_split_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        beat_valid;
  logic        beat_ack = 1'b0;
  logic [31:0] beat_addr;
  logic [2:0]  beat_size;
  logic [7:0]  beat_lanes;
  logic        beat_last;

  always #2 clk = ~clk;

  word_split_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .beat_valid(beat_valid), .beat_ack(beat_ack),
    .beat_addr(beat_addr), .beat_size(beat_size), .beat_lanes(beat_lanes),
    .beat_last(beat_last)
  );

  typedef struct {
    logic [31:0] a;
    logic [2:0]  sz;
    logic [7:0]  ln;
    logic        last;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   errors = 0;
  int   checks = 0;
  int   stall  = 1;
  int   seed   = 0;
  int   lane_sum = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] lanes_of(logic [2:0] lo, int n);
    logic [15:0] m;
    m = ((16'd1 << n) - 16'd1) << lo;
    return m[7:0];
  endfunction

  task automatic send(logic [31:0] a);
    int          off;
    logic [31:0] b;
    exp_t        e;
    off = int'(a[1:0]);
    do @(negedge clk); while (!req_ready);
    if (off == 0) begin
      e = '{a, 3'd4, lanes_of(a[2:0], 4), 1'b1, "R2"};
      sb.push_back(e);
    end else begin
      e = '{a, 3'(4 - off), lanes_of(a[2:0], 4 - off), 1'b0, "R3"};
      sb.push_back(e);
      b = {a[31:2] + 30'd1, 2'b00};
      e = '{b, 3'(off), lanes_of(b[2:0], off), 1'b1, a[2] ? "R5" : "R4"};
      sb.push_back(e);
    end
    req_addr  = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && beat_valid, "R7", "ready low after take", {31'd0, req_ready}, 32'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (beat_valid) begin
        chk(!req_ready, "R7", "ready while busy", {31'd0, req_ready}, 32'd0);
        if (sb.size() == 0) begin
          chk(1'b0, "R9", "unexpected beat", beat_addr, 32'd0);
          beat_ack <= 1'b0;
        end else begin
          chk(beat_addr == sb[0].a, sb[0].tag, "addr (R6 hold)", beat_addr, sb[0].a);
          chk(beat_size == sb[0].sz, sb[0].tag, "size", {29'd0, beat_size}, {29'd0, sb[0].sz});
          chk(beat_lanes == sb[0].ln, "R8", "lanes", {24'd0, beat_lanes}, {24'd0, sb[0].ln});
          chk(beat_last == sb[0].last, "R9", "last", {31'd0, beat_last}, {31'd0, sb[0].last});
          if (stall == 0) begin
            lane_sum += $countones(beat_lanes);
            if (beat_last) begin
              chk(lane_sum == 4, "R8", "lane total", 32'(lane_sum), 32'd4);
              lane_sum = 0;
            end
            void'(sb.pop_front());
            beat_ack <= 1'b1;
            seed++;
            stall = (seed * 7 + 1) % 3;
          end else begin
            stall--;
            beat_ack <= 1'b0;
          end
        end
      end else begin
        beat_ack <= 1'b0;
        if (sb.size() == 0)
          chk(req_ready, "R7", "ready when idle", {31'd0, req_ready}, 32'd1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready && !beat_valid, "R1", "in reset", {30'd0, req_ready, beat_valid}, 32'd2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && !beat_valid, "R1", "after reset", {30'd0, req_ready, beat_valid}, 32'd2);
    for (int k = 0; k < 8; k++) send(32'h1000_0040 + 32'(k));
    send(32'h0000_0FFD);
    send(32'h0000_0FFE);
    send(32'h0000_0FFF);
    send(32'hFFFF_FFFF);
    send(32'hFFFF_FFFD);
    send(32'hFFFF_FFFC);
    send(32'hFFFF_FFFA);
    send(32'h8765_4323);
    send(32'h8765_4321);
    send(32'h0000_0004);
    do @(negedge clk); while (sb.size() != 0 || beat_valid);
    repeat (3) @(negedge clk);
    chk(req_ready && !beat_valid, "R7", "final idle", {30'd0, req_ready, beat_valid}, 32'd2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule